// File: doc/BRIEF.md
# Card Data Path Byte Packer

This block sits between a 32-bit word FIFO that software fills or drains and a byte-wide data port on a memory card. A byte counter, loaded from a length register when software sets the enable bit of the control register, bounds each transfer. A direction bit in that control register picks the flow. When the card sends data, its bytes are gathered four at a time into words, lowest byte first, and pushed into the FIFO. When the card receives data, words are taken from the FIFO and handed to the card one byte per accepted handshake, lowest byte first.

The FIFO is a circular store with a read pointer and an occupancy count. The block derives the FIFO level flags for the active direction, raises a sticky transfer-done flag once the counter reaches zero, and drops the enable bit only when the counter is zero and the FIFO has emptied. After each software pop in the card-to-FIFO direction, card intake pauses until software strobes a status read. This gives a slow poll loop a stable FIFO.

Top module: `card_byte_packer`

## Requirements
- R1: Writing the control port with bit 0 (enable) set loads the byte counter from the 16-bit length register. The low 8 control bits are stored and can be read back. The word count output equals (counter + 3) / 4.
- R2: With control bit 1 (direction) set to 1, card bytes fill each FIFO word from bits 7:0 upward. A word is pushed after four bytes, or earlier with zero upper bytes when the counter runs out.
- R3: With direction 0, each FIFO word goes to the card least significant byte first. Bytes flow one per cycle while the card is ready and data is queued. A byte that is offered but not accepted stays unchanged.
- R4: Each byte moved decrements the counter by one. No byte is offered or accepted once the counter is zero.
- R5: Status bits 0 (done) and 1 (block done) set once the counter is zero while enabled. They stay set until the next enabling control write.
- R6: The enable bit clears by itself one cycle after the counter is zero and the FIFO is empty, and at no other time except a control write.
- R7: While enabled and not finished, status shows the FIFO level flags for the active direction only, and zeros for the other. RX group (direction 1): bit 2 active, bit 3 empty, bit 4 data available, bit 5 half full (≥8), bit 6 full. TX group (direction 0): bit 7 active, bit 8 empty, bit 9 data available, bit 10 half empty (≤8), bit 11 full (16).
- R8: The FIFO holds 16 words and keeps their order. When it is full, card intake stops (`card_rx_ready` low).
- R9: A software FIFO read when the FIFO is empty returns 0. A software FIFO write is ignored unless the block is enabled in direction 0 with a nonzero counter.
- R10: After a software FIFO pop, card intake stays stopped until `sts_rd` is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_wr | input | 1 | Length register write strobe |
| len_wdata | input | 16 | Transfer length in bytes |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value (bit 0 enable, bit 1 direction) |
| ctl_q | output | 8 | Stored control value |
| fifo_wr | input | 1 | Software FIFO push strobe |
| fifo_wdata | input | 32 | Word to push |
| fifo_rd | input | 1 | Software FIFO pop strobe |
| fifo_rdata | output | 32 | Popped word, valid the cycle after `fifo_rd` |
| sts_rd | input | 1 | Status read strobe, releases the intake pause |
| status | output | 12 | Done and FIFO flags, per R5 and R7 |
| byte_cnt | output | 16 | Remaining bytes |
| word_cnt | output | 15 | Remaining words, rounded up |
| card_rx_valid | input | 1 | Card has a byte ready |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Block accepts a card byte this cycle |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |

## Verification
A wrong lane index or a stuck partial word shows up as a corrupted word at `fifo_rdata` on the pop that follows that word. For a partial word, that is the last pop of the transfer. A bad read pointer or count shows up as reordered words or a missing full flag. The full flag is checked at the 64th byte of a 68-byte read. Errors in the unpacker show at `card_tx_data` as soon as the byte order breaks or a gap appears in the byte stream. A wrong done or enable term shows up as an enable bit that stays set, or drops early, within one cycle of the last byte or pop.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int CTL_EN  = 0;
  localparam int CTL_DIR = 1;
  localparam int ST_W    = 12;
  localparam int ST_DONE = 0;
  localparam int ST_BLK  = 1;
  localparam int ST_RACT = 2;
  localparam int ST_REMP = 3;
  localparam int ST_RAV  = 4;
  localparam int ST_RHF  = 5;
  localparam int ST_RFUL = 6;
  localparam int ST_TACT = 7;
  localparam int ST_TEMP = 8;
  localparam int ST_TAV  = 9;
  localparam int ST_THE  = 10;
  localparam int ST_TFUL = 11;
endpackage

// File: rtl/cbp_fifo.sv
module cbp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic [CNTW-1:0] level,
  output logic            empty,
  output logic            full
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   rd_ptr;
  logic [CNTW-1:0] cnt;
  logic            do_push, do_pop;
  logic [AW-1:0]   wr_ptr;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_ptr  = rd_ptr + cnt[AW-1:0];
  assign head    = mem[rd_ptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  // R8
  count_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (cnt == '0));
endmodule

// File: rtl/cbp_rx_pack.sv
module cbp_rx_pack #(
  parameter int W   = 32,
  localparam int BPW = W / 8,
  localparam int LW  = $clog2(BPW)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         take,
  input  logic [7:0]   byte_in,
  input  logic         last,
  output logic         push,
  output logic [W-1:0] word
);
  logic [W-1:0]  acc;
  logic [LW-1:0] lane;

  assign word = acc | (W'(byte_in) << (8 * lane));
  assign push = take && (lane == LW'(BPW - 1) || last);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      acc  <= '0;
      lane <= '0;
    end else if (take) begin
      if (push) begin
        acc  <= '0;
        lane <= '0;
      end else begin
        acc  <= word;
        lane <= lane + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbp_tx_unpack.sv
module cbp_tx_unpack #(
  parameter int W   = 32,
  localparam int BPW = W / 8,
  localparam int NW  = $clog2(BPW + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  input  logic         cnt_nz,
  input  logic         cnt_one,
  input  logic         fifo_empty,
  input  logic [W-1:0] head,
  input  logic         ready,
  output logic         pop,
  output logic         valid,
  output logic [7:0]   data,
  output logic         fire
);
  logic [W-1:0]  sh;
  logic [NW-1:0] left;

  assign valid = run && cnt_nz && (left != '0);
  assign fire  = valid && ready;
  assign data  = sh[7:0];
  assign pop   = run && !fifo_empty &&
                 ((left == '0) ? cnt_nz : (left == NW'(1) && fire && !cnt_one));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      left <= '0;
    end else if (pop) begin
      sh   <= head;
      left <= NW'(BPW);
    end else if (fire) begin
      sh   <= sh >> 8;
      left <= left - 1'b1;
    end
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> $stable(data));
endmodule

// File: rtl/card_byte_packer.sv
module card_byte_packer
  import cbp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int BSH   = $clog2(WORD_W / 8),
  localparam int WC_W  = CNT_W + 1 - BSH,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              len_wr,
  input  logic [CNT_W-1:0]  len_wdata,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_q,
  input  logic              fifo_wr,
  input  logic [WORD_W-1:0] fifo_wdata,
  input  logic              fifo_rd,
  output logic [WORD_W-1:0] fifo_rdata,
  input  logic              sts_rd,
  output logic [ST_W-1:0]   status,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic [WC_W-1:0]   word_cnt,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready
);
  logic [CNT_W-1:0]  len_q, cnt_q;
  logic              en, dir, ld, cnt_nz, cnt_one, hold, done_q;
  logic              take, rx_push, tx_pop, tx_fire, sw_push, sw_pop;
  logic              f_push, f_pop, f_empty, f_full, finished;
  logic [WORD_W-1:0] rx_word, f_head, f_wdata;
  logic [LVL_W-1:0]  f_level;

  assign en      = ctl_q[CTL_EN];
  assign dir     = ctl_q[CTL_DIR];
  assign ld      = ctl_wr && ctl_wdata[CTL_EN];
  assign cnt_nz  = (cnt_q != '0);
  assign cnt_one = (cnt_q == CNT_W'(1));

  assign card_rx_ready = en && dir && cnt_nz && !hold && !f_full;
  assign take          = card_rx_ready && card_rx_valid;
  assign sw_push       = fifo_wr && en && !dir && cnt_nz;
  assign sw_pop        = fifo_rd && (dir || !en);
  assign f_push        = rx_push || sw_push;
  assign f_wdata       = rx_push ? rx_word : fifo_wdata;
  assign f_pop         = tx_pop || sw_pop;
  assign finished      = !cnt_nz && f_empty;

  cbp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(f_push), .push_data(f_wdata), .pop(f_pop),
    .head(f_head), .level(f_level), .empty(f_empty), .full(f_full));

  cbp_rx_pack #(.W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .start(ld), .take(take), .byte_in(card_rx_data),
    .last(cnt_one), .push(rx_push), .word(rx_word));

  cbp_tx_unpack #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .start(ld), .run(en && !dir), .cnt_nz(cnt_nz),
    .cnt_one(cnt_one), .fifo_empty(f_empty), .head(f_head),
    .ready(card_tx_ready), .pop(tx_pop), .valid(card_tx_valid),
    .data(card_tx_data), .fire(tx_fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q      <= '0;
      cnt_q      <= '0;
      ctl_q      <= '0;
      hold       <= 1'b0;
      done_q     <= 1'b0;
      fifo_rdata <= '0;
    end else begin
      if (len_wr) len_q <= len_wdata;
      if (ld) cnt_q <= len_q;
      else if (take || tx_fire) cnt_q <= cnt_q - 1'b1;
      if (ctl_wr) ctl_q <= ctl_wdata;
      else if (en && finished) ctl_q[CTL_EN] <= 1'b0;
      if (ld) done_q <= 1'b0;
      else if (en && !cnt_nz) done_q <= 1'b1;
      if (sw_pop && !f_empty) hold <= 1'b1;
      else if (sts_rd) hold <= 1'b0;
      if (fifo_rd) fifo_rdata <= (sw_pop && !f_empty) ? f_head : '0;
    end
  end

  always_comb begin
    logic act;
    act    = en && !finished;
    status = '0;
    status[ST_DONE] = done_q;
    status[ST_BLK]  = done_q;
    status[ST_RACT] = act && dir;
    status[ST_REMP] = act && dir && f_empty;
    status[ST_RAV]  = act && dir && !f_empty;
    status[ST_RHF]  = act && dir && (f_level >= LVL_W'(DEPTH / 2));
    status[ST_RFUL] = act && dir && f_full;
    status[ST_TACT] = act && !dir;
    status[ST_TEMP] = act && !dir && f_empty;
    status[ST_TAV]  = act && !dir && !f_empty;
    status[ST_THE]  = act && !dir && (f_level <= LVL_W'(DEPTH / 2));
    status[ST_TFUL] = act && !dir && f_full;
  end

  assign byte_cnt = cnt_q;
  assign word_cnt = WC_W'(({1'b0, cnt_q} + (CNT_W + 1)'((1 << BSH) - 1)) >> BSH);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  // R6
  en_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl_q[CTL_EN]) && !$past(ctl_wr)) |-> ($past(cnt_q) == '0 && $past(f_empty)));
  // R10
  hold_block_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !card_rx_ready);
  // R4
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> (!card_rx_ready && !card_tx_valid));
endmodule

// File: tb/card_byte_packer_bench.sv
module card_byte_packer_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic len_wr = 0, ctl_wr = 0, fifo_wr = 0, fifo_rd = 0, sts_rd = 0;
  logic [15:0] len_wdata = 0;
  logic [7:0]  ctl_wdata = 0, ctl_q;
  logic [31:0] fifo_wdata = 0, fifo_rdata;
  logic [11:0] status;
  logic [15:0] byte_cnt;
  logic [14:0] word_cnt;
  logic card_rx_valid = 0, card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0] card_rx_data = 0, card_tx_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] got [16];
  int got_cyc [16];
  int ngot = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  card_byte_packer u_card_byte_packer (.*);

  always @(negedge clk)
    if (!rst && card_tx_valid && card_tx_ready && ngot < 16) begin
      got[ngot] = card_tx_data; got_cyc[ngot] = cyc; ngot++;
    end

  // {length, first byte}; bytes then count upward
  localparam logic [15:0] VEC [5] = '{16'h0410, 16'h0630, 16'h0150, 16'h0870, 16'h0390};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic set_len(input logic [15:0] l);
    @(negedge clk); len_wr = 1; len_wdata = l; @(negedge clk); len_wr = 0;
  endtask
  task automatic set_ctl(input logic [7:0] c);
    @(negedge clk); ctl_wr = 1; ctl_wdata = c; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!card_rx_ready) @(negedge clk);
    card_rx_valid = 1; card_rx_data = b;
    @(negedge clk); card_rx_valid = 0;
  endtask
  task automatic pop_word(output logic [31:0] w);
    @(negedge clk); fifo_rd = 1; @(negedge clk); fifo_rd = 0; w = fifo_rdata;
  endtask
  task automatic poll;
    @(negedge clk); sts_rd = 1; @(negedge clk); sts_rd = 0;
  endtask
  task automatic push_word(input logic [31:0] w);
    @(negedge clk); fifo_wr = 1; fifo_wdata = w; @(negedge clk); fifo_wr = 0;
  endtask

  initial begin
    logic [31:0] w, e;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ctl_q == 0 && status == 0 && !card_rx_ready && !card_tx_valid, "R6 reset", {ctl_q, status}, 0);

    // R2: packing over the vector table
    for (int v = 0; v < 5; v++) begin
      int l; logic [7:0] b0;
      l = int'(VEC[v][15:8]); b0 = VEC[v][7:0];
      set_len(16'(l));
      set_ctl(8'h03);
      chk(byte_cnt == 16'(l) && word_cnt == 15'((l + 3) / 4), "R1 load", byte_cnt, l);
      for (int i = 0; i < l; i++) send_byte(b0 + 8'(i));
      for (int k = 0; k < (l + 3) / 4; k++) begin
        e = 0;
        for (int j = 0; j < 4; j++)
          if (4 * k + j < l) e[8*j +: 8] = b0 + 8'(4 * k + j);
        pop_word(w);
        chk(w == e, "R2 packed word", w, e);
        poll;
      end
      chk(ctl_q[0] == 0 && status[1:0] == 2'b11, "R5 R6 done", {ctl_q, status}, 3);
    end

    // R8 R10: fill to full, hold after pop, drain in order
    set_len(16'd68);
    set_ctl(8'h03);
    chk(word_cnt == 15'd17, "R1 word count", word_cnt, 17);
    chk(ctl_q == 8'h03, "R1 ctl readback", ctl_q, 3);
    for (int i = 0; i < 64; i++) send_byte(8'(i));
    chk(!card_rx_ready && byte_cnt == 16'd4, "R8 full stops intake", byte_cnt, 4);
    chk(status[6] && status[5] && status[2] && status[11:7] == 0, "R7 rx flags full", status, 12'h064);
    pop_word(w);
    chk(w == 32'h03020100, "R8 first word", w, 32'h03020100);
    repeat (2) @(negedge clk);
    chk(!card_rx_ready, "R10 hold after pop", card_rx_ready, 0);
    poll;
    chk(card_rx_ready, "R10 released by poll", card_rx_ready, 1);
    for (int i = 64; i < 68; i++) send_byte(8'(i));
    for (int k = 1; k < 17; k++) begin
      e = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
      pop_word(w);
      chk(w == e, "R8 order", w, e);
      poll;
    end
    chk(ctl_q[0] == 0, "R6 idle after drain", ctl_q, 0);

    // R9: empty read and ignored write
    push_word(32'hDEADBEEF);
    pop_word(w);
    chk(w == 0, "R9 ignored write, empty read", w, 0);

    // R7 R3 R4: write direction
    set_len(16'd6);
    set_ctl(8'h01);
    chk(status[7] && status[8] && status[10] && !status[9] && !status[11] && status[6:2] == 0,
        "R7 tx flags empty", status, 12'h580);
    chk(!card_tx_valid, "R4 no byte without data", card_tx_valid, 0);
    push_word(32'h44332211);
    repeat (3) @(negedge clk);
    chk(card_tx_valid && card_tx_data == 8'h11, "R3 stalled first byte", card_tx_data, 8'h11);
    push_word(32'h88776655);
    card_tx_ready = 1;
    repeat (12) @(negedge clk);
    card_tx_ready = 0;
    chk(ngot == 6, "R4 byte total", ngot, 6);
    for (int i = 0; i < 6; i++)
      chk(got[i] == 8'h11 * 8'(i + 1), "R3 byte order", got[i], 8'h11 * (i + 1));
    chk(got_cyc[5] - got_cyc[0] == 5, "R3 one per cycle", got_cyc[5] - got_cyc[0], 5);
    chk(byte_cnt == 0 && ctl_q[0] == 0 && status[0], "R5 R6 tx done", {ctl_q, status}, 1);
    set_ctl(8'h00);
    chk(status[0] == 1, "R5 sticky without enable", status[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule